// File: doc/BRIEF.md
# Memory-Mapped Crypto Engine Dispatcher

This block is an AXI4-Lite slave that lets a processor drive three multi-cycle cryptographic engines (block cipher, hash and stream cipher) using nothing more than loads and stores. Software picks an engine code, fills a 32-word shared operand window, writes a launch bit and then polls a flag word. A four-state sequencer (idle, dispatch, wait, finish) sends one start pulse to the chosen engine only. It then waits for that engine's done line and records the outcome in the flag word.

The operand window is visible to the engines as a flat bus. The running engine writes its results back through a one-word result port. Bus writes to the window are dropped while a run is in flight, so the operands stay stable. Launch requests made while a run is in progress are ignored. A launch with an unused engine code raises an error flag and starts nothing.

Top module: `cpx_dispatch`

## Requirements
- R1: Address map: 0x00 launch (write-only), 0x04 flags (read-only), 0x08 engine code (write-only), 0x10 to 0x8C window words 0 to 31 (read/write). Reads of 0x00, 0x08 and every unmapped offset return zero with an OKAY response.
- R2: A write is accepted whether AW comes before W, W comes before AW, or both arrive together. BRESP is OKAY (2'b00), and BVALID stays high until BREADY is seen.
- R3: On a read, RVALID stays high and RDATA stays stable until RREADY is seen. RRESP is OKAY.
- R4: Writing 1 to bit 0 of the launch register while idle, with a valid code (0 = block cipher, 1 = hash, 2 = stream cipher), produces exactly one start pulse, and only on eng_start[code]. The pulse waits until eng_ready[code] is high.
- R5: The flag word has BUSY at bit 0, DONE at bit 1 and ERR at bit 2. BUSY is high from the accepted launch until the selected engine reports done.
- R6: While a run is waiting, a done pulse from any engine other than the selected one is ignored.
- R7: DONE is set when the run finishes, stays set across reads, and is cleared by the next accepted launch.
- R8: A launch written while BUSY is set produces no further start pulse and does not change the run.
- R9: A launch with code 3 sets ERR, leaves DONE clear, starts no engine and keeps the sequencer idle. The next valid launch clears ERR.
- R10: While BUSY is set, bus writes to the window are dropped but still get an OKAY response. Reads of the window are always served.
- R11: Window bus writes honour WSTRB byte lanes. A result-port write replaces a whole word, and the window contents appear on buf_words, word i at bits [32*i+31:32*i].
- R12: A launch register write with bit 0 clear has no effect on the flags or the engines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 8 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 8 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| eng_start | output | 3 | One-cycle start, one line per engine |
| eng_ready | input | 3 | Engine able to take a start |
| eng_done | input | 3 | One-cycle completion, one line per engine |
| res_we | input | 1 | Result-port write enable |
| res_idx | input | 5 | Result-port word index |
| res_data | input | 32 | Result-port data |
| buf_words | output | 1024 | Window contents, flat |

## Verification
The bench goes after the cases where a sloppy sequencer misbehaves. A second launch during a run would send a duplicate start pulse. A done from the wrong engine would end the run early and raise DONE while the real engine is still working. A launch with code 3 would either hang in dispatch or pulse an engine beyond the valid set. A window write during a run would corrupt operands the engine is reading. The bench also checks write handshakes in all three AW/W orders, held responses, and start pulses held back by a low ready line; a wrong handshake would drop or double a register write.

// File: rtl/cpx_pkg.sv
`timescale 1ns/1ps
package cpx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_DISPATCH = 2'd1,
      ST_WAIT     = 2'd2,
      ST_FIN      = 2'd3
   } cpx_state_e;

   localparam int OFF_LAUNCH = 'h00;
   localparam int OFF_FLAGS  = 'h04;
   localparam int OFF_CODE   = 'h08;

   localparam int FLAG_BUSY = 0;
   localparam int FLAG_DONE = 1;
   localparam int FLAG_ERR  = 2;

   localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/cpx_axi_port.sv
`timescale 1ns/1ps
module cpx_axi_port #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   localparam int STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic [STRB_W-1:0] s_wstrb,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [STRB_W-1:0] wr_strb,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data
);
   import cpx_pkg::*;

   logic              aw_q, w_q, bvalid_q, rvalid_q;
   logic [ADDR_W-1:0] awaddr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q;
   logic [STRB_W-1:0] wstrb_q;

   assign s_awready = !aw_q && !bvalid_q;
   assign s_wready  = !w_q && !bvalid_q;
   assign wr_en     = aw_q && w_q && !bvalid_q;
   assign wr_addr   = awaddr_q;
   assign wr_data   = wdata_q;
   assign wr_strb   = wstrb_q;
   assign s_bvalid  = bvalid_q;
   assign s_bresp   = RESP_OKAY;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aw_q     <= 1'b0;
         w_q      <= 1'b0;
         bvalid_q <= 1'b0;
         awaddr_q <= '0;
         wdata_q  <= '0;
         wstrb_q  <= '0;
      end else begin
         if (s_awvalid && s_awready) begin
            aw_q     <= 1'b1;
            awaddr_q <= s_awaddr;
         end
         if (s_wvalid && s_wready) begin
            w_q     <= 1'b1;
            wdata_q <= s_wdata;
            wstrb_q <= s_wstrb;
         end
         if (wr_en) begin
            aw_q     <= 1'b0;
            w_q      <= 1'b0;
            bvalid_q <= 1'b1;
         end else if (bvalid_q && s_bready) begin
            bvalid_q <= 1'b0;
         end
      end
   end

   assign s_arready = !rvalid_q;
   assign rd_addr   = s_araddr;
   assign s_rvalid  = rvalid_q;
   assign s_rdata   = rdata_q;
   assign s_rresp   = RESP_OKAY;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else if (s_arvalid && s_arready) begin
         rvalid_q <= 1'b1;
         rdata_q  <= rd_data;
      end else if (rvalid_q && s_rready) begin
         rvalid_q <= 1'b0;
      end
   end
endmodule

// File: rtl/cpx_window.sv
`timescale 1ns/1ps
module cpx_window #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 32,
   localparam int IDX_W  = $clog2(WORDS),
   localparam int STRB_W = DATA_W / 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_we,
   input  logic [IDX_W-1:0]        bus_idx,
   input  logic [DATA_W-1:0]       bus_data,
   input  logic [STRB_W-1:0]       bus_strb,
   input  logic                    core_we,
   input  logic [IDX_W-1:0]        core_idx,
   input  logic [DATA_W-1:0]       core_data,
   input  logic [IDX_W-1:0]        rd_idx,
   output logic [DATA_W-1:0]       rd_data,
   output logic [WORDS*DATA_W-1:0] words_flat
);
   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (core_we && core_idx == IDX_W'(w)) begin
            word_q <= core_data;
         end else if (bus_we && bus_idx == IDX_W'(w)) begin
            for (int b = 0; b < STRB_W; b++) begin
               if (bus_strb[b]) word_q[b*8 +: 8] <= bus_data[b*8 +: 8];
            end
         end
      end
      assign words_flat[w*DATA_W +: DATA_W] = word_q;
   end

   assign rd_data = words_flat[rd_idx*DATA_W +: DATA_W];
endmodule

// File: rtl/cpx_sequencer.sv
`timescale 1ns/1ps
module cpx_sequencer #(
   parameter int NUM_ENG = 3,
   localparam int SEL_W  = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch,
   input  logic [SEL_W-1:0]   code,
   input  logic [NUM_ENG-1:0] eng_ready,
   input  logic [NUM_ENG-1:0] eng_done,
   output logic [NUM_ENG-1:0] eng_start,
   output logic               busy,
   output logic               done_flag,
   output logic               err_flag
);
   import cpx_pkg::*;

   cpx_state_e         state_q;
   logic [SEL_W-1:0]   run_q;
   logic [NUM_ENG-1:0] run_hot;
   logic               code_ok;

   assign code_ok = (32'(code) < NUM_ENG);

   for (genvar i = 0; i < NUM_ENG; i++) begin : g_eng
      assign run_hot[i]   = (run_q == SEL_W'(i));
      assign eng_start[i] = (state_q == ST_DISPATCH) && run_hot[i] && eng_ready[i];
   end

   assign busy = (state_q == ST_DISPATCH) || (state_q == ST_WAIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         run_q     <= '0;
         done_flag <= 1'b0;
         err_flag  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (launch) begin
                  done_flag <= 1'b0;
                  if (code_ok) begin
                     err_flag <= 1'b0;
                     run_q    <= code;
                     state_q  <= ST_DISPATCH;
                  end else begin
                     err_flag <= 1'b1;
                  end
               end
            end
            ST_DISPATCH: if (|eng_start) state_q <= ST_WAIT;
            ST_WAIT: begin
               if (|(run_hot & eng_done)) begin
                  done_flag <= 1'b1;
                  state_q   <= ST_FIN;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cpx_dispatch.sv
`timescale 1ns/1ps
module cpx_dispatch #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int BUF_WORDS = 32,
   parameter int BUF_BASE  = 'h10,
   parameter int NUM_ENG   = 3,
   localparam int IDX_W  = $clog2(BUF_WORDS),
   localparam int STRB_W = DATA_W / 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           s_awaddr,
   input  logic                        s_awvalid,
   output logic                        s_awready,
   input  logic [DATA_W-1:0]           s_wdata,
   input  logic [STRB_W-1:0]           s_wstrb,
   input  logic                        s_wvalid,
   output logic                        s_wready,
   output logic [1:0]                  s_bresp,
   output logic                        s_bvalid,
   input  logic                        s_bready,
   input  logic [ADDR_W-1:0]           s_araddr,
   input  logic                        s_arvalid,
   output logic                        s_arready,
   output logic [DATA_W-1:0]           s_rdata,
   output logic [1:0]                  s_rresp,
   output logic                        s_rvalid,
   input  logic                        s_rready,
   output logic [NUM_ENG-1:0]          eng_start,
   input  logic [NUM_ENG-1:0]          eng_ready,
   input  logic [NUM_ENG-1:0]          eng_done,
   input  logic                        res_we,
   input  logic [IDX_W-1:0]            res_idx,
   input  logic [DATA_W-1:0]           res_data,
   output logic [BUF_WORDS*DATA_W-1:0] buf_words
);
   import cpx_pkg::*;

   localparam int SEL_W   = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1;
   localparam int BUF_END = BUF_BASE + 4 * BUF_WORDS;

   initial begin
      assert (DATA_W >= 32 && DATA_W % 8 == 0) else $error("DATA_W must be bytes, at least 32");
      assert (BUF_END <= (1 << ADDR_W)) else $error("window exceeds address space");
      assert (BUF_BASE % 4 == 0 && BUF_BASE > OFF_CODE) else $error("window base misplaced");
      assert (NUM_ENG >= 1 && SEL_W <= 8) else $error("bad engine count");
   end

   function automatic logic in_window(input logic [ADDR_W-1:0] a);
      return (32'(a) >= BUF_BASE) && (32'(a) < BUF_END);
   endfunction

   function automatic logic [IDX_W-1:0] win_idx(input logic [ADDR_W-1:0] a);
      return IDX_W'((32'(a) - BUF_BASE) >> 2);
   endfunction

   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [DATA_W-1:0] wr_data, rd_mux, win_rd;
   logic [STRB_W-1:0] wr_strb;
   logic [SEL_W-1:0]  code_q;
   logic              launch, seq_busy, seq_done, seq_err;

   cpx_axi_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk, .rst_n,
      .s_awaddr, .s_awvalid, .s_awready,
      .s_wdata, .s_wstrb, .s_wvalid, .s_wready,
      .s_bresp, .s_bvalid, .s_bready,
      .s_araddr, .s_arvalid, .s_arready,
      .s_rdata, .s_rresp, .s_rvalid, .s_rready,
      .wr_en, .wr_addr, .wr_data, .wr_strb,
      .rd_addr, .rd_data(rd_mux)
   );

   assign launch = wr_en && (wr_addr == ADDR_W'(OFF_LAUNCH)) && wr_strb[0] && wr_data[0];

   always_ff @(posedge clk) begin
      if (!rst_n) code_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(OFF_CODE) && wr_strb[0]) code_q <= wr_data[SEL_W-1:0];
   end

   cpx_window #(.DATA_W(DATA_W), .WORDS(BUF_WORDS)) u_win (
      .clk, .rst_n,
      .bus_we   (wr_en && in_window(wr_addr) && !seq_busy),
      .bus_idx  (win_idx(wr_addr)),
      .bus_data (wr_data),
      .bus_strb (wr_strb),
      .core_we  (res_we),
      .core_idx (res_idx),
      .core_data(res_data),
      .rd_idx   (win_idx(rd_addr)),
      .rd_data  (win_rd),
      .words_flat(buf_words)
   );

   cpx_sequencer #(.NUM_ENG(NUM_ENG)) u_seq (
      .clk, .rst_n,
      .launch, .code(code_q),
      .eng_ready, .eng_done, .eng_start,
      .busy(seq_busy), .done_flag(seq_done), .err_flag(seq_err)
   );

   always_comb begin
      rd_mux = '0;
      if (rd_addr == ADDR_W'(OFF_FLAGS)) begin
         rd_mux[FLAG_BUSY] = seq_busy;
         rd_mux[FLAG_DONE] = seq_done;
         rd_mux[FLAG_ERR]  = seq_err;
      end else if (in_window(rd_addr)) begin
         rd_mux = win_rd;
      end
   end
endmodule

// File: rtl/cpx_dispatch_chk.sv
`timescale 1ns/1ps
module cpx_dispatch_chk #(
   parameter int NUM_ENG = 3,
   parameter int DATA_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_ENG-1:0] eng_start,
   input logic [NUM_ENG-1:0] eng_ready,
   input logic               busy,
   input logic               done_flag,
   input logic               err_flag,
   input logic               bvalid,
   input logic               bready,
   input logic [1:0]         bresp,
   input logic               rvalid,
   input logic               rready,
   input logic [DATA_W-1:0]  rdata,
   input logic [1:0]         rresp
);
   AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(eng_start)); // R4
   AST_START_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n) (eng_start & ~eng_ready) == '0); // R4
   AST_START_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) |eng_start |-> busy); // R5
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) |eng_start |=> eng_start == '0); // R8
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done_flag |-> !busy); // R7
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done_flag && err_flag)); // R9
   AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n) bvalid && !bready |=> bvalid); // R2
   AST_BRESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n) bvalid |-> bresp == 2'b00); // R2
   AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rvalid && !rready |=> rvalid && $stable(rdata)); // R3
   AST_RRESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n) rvalid |-> rresp == 2'b00); // R3
endmodule

bind cpx_dispatch cpx_dispatch_chk #(.NUM_ENG(NUM_ENG), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .eng_start(eng_start), .eng_ready(eng_ready),
   .busy(seq_busy), .done_flag(seq_done), .err_flag(seq_err),
   .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
   .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp)
);

// File: tb/sim_cpx_dispatch.sv
`timescale 1ns/1ps
module sim_cpx_dispatch;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [7:0]  s_awaddr = 0, s_araddr = 0;
   logic        s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
   logic [31:0] s_wdata = 0;
   logic [3:0]  s_wstrb = 0;
   logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
   logic [1:0]  s_bresp, s_rresp;
   logic [31:0] s_rdata;
   logic [2:0]  eng_start;
   logic [2:0]  eng_ready = 3'b111, eng_done = 3'b000;
   logic        res_we = 0;
   logic [4:0]  res_idx = 0;
   logic [31:0] res_data = 0;
   logic [1023:0] buf_words;

   int n_chk = 0, n_fail = 0;
   int starts[3] = '{0, 0, 0};

   always #4 clk = ~clk;

   cpx_dispatch u0 (
      .clk, .rst_n,
      .s_awaddr, .s_awvalid, .s_awready, .s_wdata, .s_wstrb, .s_wvalid, .s_wready,
      .s_bresp, .s_bvalid, .s_bready,
      .s_araddr, .s_arvalid, .s_arready, .s_rdata, .s_rresp, .s_rvalid, .s_rready,
      .eng_start, .eng_ready, .eng_done,
      .res_we, .res_idx, .res_data, .buf_words
   );

   always @(negedge clk) begin
      for (int i = 0; i < 3; i++) if (eng_start[i]) starts[i]++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic axi_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                            input int ord, input int bdly);
      bit aw_done = 0, w_done = 0;
      @(negedge clk);
      if (ord != 1) begin s_awaddr = a; s_awvalid = 1; end
      if (ord != 0) begin s_wdata = d; s_wstrb = s; s_wvalid = 1; end
      for (int n = 0; n < 40 && !(aw_done && w_done); n++) begin
         bit ah, wh;
         ah = s_awvalid && s_awready;
         wh = s_wvalid && s_wready;
         @(posedge clk); @(negedge clk);
         if (ah) begin s_awvalid = 0; aw_done = 1; end
         if (wh) begin s_wvalid = 0; w_done = 1; end
         if (ord == 0 && aw_done && !w_done && !s_wvalid) begin s_wdata = d; s_wstrb = s; s_wvalid = 1; end
         if (ord == 1 && w_done && !aw_done && !s_awvalid) begin s_awaddr = a; s_awvalid = 1; end
      end
      for (int n = 0; n < 40 && !s_bvalid; n++) @(negedge clk);
      if (bdly > 0) begin
         for (int n = 0; n < bdly; n++) @(negedge clk);
         chk("R2 bvalid held without bready", 32'(s_bvalid), 32'd1);
      end
      chk("R2 write response", 32'({s_bvalid, s_bresp}), 32'b100);
      s_bready = 1;
      @(posedge clk); @(negedge clk);
      s_bready = 0;
   endtask

   task automatic axi_read(input logic [7:0] a, input int rdly, output logic [31:0] d);
      @(negedge clk);
      s_araddr = a; s_arvalid = 1;
      for (int n = 0; n < 40 && !s_arready; n++) @(negedge clk);
      @(posedge clk); @(negedge clk);
      s_arvalid = 0;
      for (int n = 0; n < 40 && !s_rvalid; n++) @(negedge clk);
      d = s_rdata;
      chk("R3 read response", 32'({s_rvalid, s_rresp}), 32'b100);
      if (rdly > 0) begin
         for (int n = 0; n < rdly; n++) @(negedge clk);
         chk("R3 rdata held", s_rdata, d);
      end
      s_rready = 1;
      @(posedge clk); @(negedge clk);
      s_rready = 0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      axi_write(a, d, 4'hF, 2, 0);
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      axi_read(a, 0, v);
      chk(req, v, exp);
   endtask

   task automatic pulse_done(input int e);
      @(negedge clk); eng_done[e] = 1;
      @(negedge clk); eng_done[e] = 0;
   endtask

   task automatic t_reset();
      rd_chk("R5 flags after reset", 8'h04, 32'h0);
      chk("R4 no start after reset", 32'(eng_start), 32'h0);
      rd_chk("R11 window after reset", 8'h10, 32'h0);
   endtask

   task automatic t_map();
      logic [31:0] v;
      wr(8'h10, 32'hA5A5_0001);
      wr(8'h8C, 32'h5A5A_001F);
      rd_chk("R1 window word 0", 8'h10, 32'hA5A5_0001);
      axi_read(8'h8C, 3, v);
      chk("R1 window word 31", v, 32'h5A5A_001F);
      rd_chk("R1 launch reads zero", 8'h00, 32'h0);
      wr(8'h08, 32'h2);
      rd_chk("R1 code reads zero", 8'h08, 32'h0);
      rd_chk("R1 unmapped 0x90", 8'h90, 32'h0);
      rd_chk("R1 unmapped 0xFC", 8'hFC, 32'h0);
      rd_chk("R1 unmapped 0x0C", 8'h0C, 32'h0);
   endtask

   task automatic t_order();
      axi_write(8'h14, 32'h1111_0000, 4'hF, 0, 0);
      axi_write(8'h18, 32'h2222_0000, 4'hF, 1, 3);
      axi_write(8'h1C, 32'h3333_0000, 4'hF, 2, 0);
      rd_chk("R2 AW before W", 8'h14, 32'h1111_0000);
      rd_chk("R2 W before AW", 8'h18, 32'h2222_0000);
      rd_chk("R2 AW with W", 8'h1C, 32'h3333_0000);
   endtask

   task automatic t_run(input int code);
      int s0[3];
      int other;
      logic [31:0] v;
      other = (code + 1) % 3;
      wr(8'h08, 32'(code));
      for (int i = 0; i < 3; i++) s0[i] = starts[i];
      wr(8'h00, 32'h1);
      for (int i = 0; i < 3; i++)
         chk($sformatf("R4 code %0d start count eng %0d", code, i), 32'(starts[i] - s0[i]), (i == code) ? 32'd1 : 32'd0);
      rd_chk("R5 busy during run", 8'h04, 32'h1);
      pulse_done(other);
      rd_chk("R6 foreign done ignored", 8'h04, 32'h1);
      wr(8'h00, 32'h1);
      chk("R8 no retrigger", 32'(starts[code] - s0[code]), 32'd1);
      axi_read(8'h20, 0, v);
      wr(8'h20, ~v);
      rd_chk("R10 window write dropped while busy", 8'h20, v);
      pulse_done(code);
      rd_chk("R7 done after run", 8'h04, 32'h2);
      rd_chk("R7 done sticky", 8'h04, 32'h2);
   endtask

   task automatic t_ready();
      int s0;
      wr(8'h08, 32'h1);
      eng_ready[1] = 0;
      s0 = starts[1];
      wr(8'h00, 32'h1);
      repeat (10) @(negedge clk);
      chk("R4 start held for ready", 32'(starts[1] - s0), 32'd0);
      rd_chk("R5 busy while dispatching", 8'h04, 32'h1);
      eng_ready[1] = 1;
      repeat (2) @(negedge clk);
      chk("R4 start after ready", 32'(starts[1] - s0), 32'd1);
      pulse_done(1);
      rd_chk("R7 done after gated run", 8'h04, 32'h2);
   endtask

   task automatic t_bad_code();
      int tot;
      tot = starts[0] + starts[1] + starts[2];
      wr(8'h08, 32'h3);
      wr(8'h00, 32'h1);
      repeat (3) @(negedge clk);
      rd_chk("R9 err with code 3", 8'h04, 32'h4);
      chk("R9 no start on code 3", 32'(starts[0] + starts[1] + starts[2] - tot), 32'd0);
      wr(8'h08, 32'h0);
      wr(8'h00, 32'h1);
      rd_chk("R9 err cleared by valid launch", 8'h04, 32'h1);
      pulse_done(0);
      rd_chk("R7 done after recovery", 8'h04, 32'h2);
   endtask

   task automatic t_zero_launch();
      int tot;
      tot = starts[0] + starts[1] + starts[2];
      wr(8'h00, 32'h0);
      wr(8'h00, 32'hFFFF_FFFE);
      rd_chk("R12 flags unchanged", 8'h04, 32'h2);
      chk("R12 no start", 32'(starts[0] + starts[1] + starts[2] - tot), 32'd0);
   endtask

   task automatic t_strobe();
      axi_write(8'h24, 32'h1122_3344, 4'hF, 2, 0);
      axi_write(8'h24, 32'hFFFF_ABFF, 4'b0010, 0, 0);
      rd_chk("R11 byte strobe merge", 8'h24, 32'h1122_AB44);
      @(negedge clk);
      res_we = 1; res_idx = 5'd7; res_data = 32'hDEAD_BEEF;
      @(negedge clk);
      res_we = 0;
      rd_chk("R11 result port word", 8'h2C, 32'hDEAD_BEEF);
      chk("R11 flat bus word 7", buf_words[7*32 +: 32], 32'hDEAD_BEEF);
      chk("R11 flat bus word 5", buf_words[5*32 +: 32], 32'h1122_AB44);
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_map();
      t_order();
      for (int c = 0; c < 3; c++) t_run(c);
      t_ready();
      t_bad_code();
      t_zero_launch();
      t_strobe();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule